// File: doc/BRIEF.md
# Buffer-Aligned Write Chunk Splitter

This block sits in front of a buffered-program engine for an array of identical flash chips. It accepts one long write request, given as a byte offset into the whole array and a byte length. It turns that request into a series of chunk commands. Each command names a chip, an offset inside that chip and a byte count. No chunk runs past the end of a program buffer or past the end of a chip. The data itself does not pass through this block. It produces only the addresses and sizes.

The block issues one command at a time and holds it until the engine answers with done or error. On done it advances its position and adds the chunk size to a running byte total. An error stops the request at once. When the request ends, the block raises a one-cycle finish strobe that carries the error flag, the error code and the number of bytes retired. A request ends when its length is used up, when the last chip fills, or when an error occurs. The size of one chip and the size of the buffer in one chip are powers of two. The buffer seen by the engine is the per-chip buffer widened by the interleave factor.

Top module: `wchunk_splitter`

## Requirements
- R1: While reset is asserted and after it is released, req_ready is 1 and cmd_valid and fin_valid are 0.
- R2: A request accepted with req_len of 0 issues no command. It raises fin_valid on the next cycle with fin_err 0 and fin_bytes 0.
- R3: The first command of a request carries cmd_chip equal to req_offset shifted right by CHIP_SHIFT, and cmd_offset equal to the low CHIP_SHIFT bits of req_offset.
- R4: Every cmd_size equals B minus (cmd_offset AND (B-1)), clipped to the bytes still owed. B is 2 to the power (BUF_LOG2 + ILV_LOG2).
- R5: When a completed chunk brings the in-chip offset to 2^CHIP_SHIFT, the next command is issued to cmd_chip plus 1 at cmd_offset 0. Otherwise the next command starts at cmd_offset plus cmd_size on the same chip.
- R6: When a chunk fills chip NCHIP-1, the request ends successfully with fin_err 0, even if bytes are still owed.
- R7: Only one command is outstanding at a time. cmd_chip, cmd_offset and cmd_size hold steady while neither cmd_done nor cmd_err is asserted. The next command appears on the cycle after cmd_done.
- R8: cmd_err aborts the request. The next cycle shows fin_valid with fin_err 1, fin_code equal to cmd_err_code, and fin_bytes counting only the chunks completed before it. When cmd_err and cmd_done are both asserted, cmd_err takes priority.
- R9: fin_bytes at fin_valid is the sum of the sizes of all chunks completed with done. fin_valid lasts one cycle, after which req_ready returns to 1.
- R10: A request whose starting chip index is NCHIP or more completes on the next cycle with fin_err 0 and fin_bytes 0, and issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is 1 |
| req_offset | input | ADDR_W | Byte offset into the whole array |
| req_len | input | LEN_W | Request length in bytes |
| req_ready | output | 1 | Block idle and able to take a request |
| cmd_valid | output | 1 | Chunk command is outstanding |
| cmd_chip | output | ADDR_W-CHIP_SHIFT | Chip index of the chunk |
| cmd_offset | output | CHIP_SHIFT | Byte offset inside the chip |
| cmd_size | output | LEN_W | Chunk size in bytes |
| cmd_done | input | 1 | Engine finished the chunk successfully |
| cmd_err | input | 1 | Engine failed the chunk |
| cmd_err_code | input | ERR_W | Error code that goes with cmd_err |
| fin_valid | output | 1 | One-cycle request completion strobe |
| fin_err | output | 1 | Request ended on an error |
| fin_code | output | ERR_W | Error code captured from the engine |
| fin_bytes | output | LEN_W | Bytes retired by the request |

## Verification
A wrong in-chip offset or a wrong remaining count shows up in cmd_size as soon as the next command is issued, one cycle after the done that caused it. This is because the size depends on the alignment of the offset and on the bytes still owed. A bad rollover shows up on the same cycle as a wrong cmd_chip, or as a missing zero in cmd_offset. At the last chip it shows up as a request that does not end. A wrong byte accumulator is visible only at the finish strobe, so each request's fin_bytes is compared against the sum of the sizes that were acknowledged. Requests that end on errors are compared the same way.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FIN   = 2'd2
  } wcs_state_e;
endpackage

// File: rtl/wcs_chunk_calc.sv
// Combinational size of the current chunk and chip-end detection.
module wcs_chunk_calc #(
  parameter int CHIP_SHIFT = 12,
  parameter int EBUF_LOG2  = 5,
  parameter int LEN_W      = 16
) (
  input  logic [CHIP_SHIFT-1:0] off,
  input  logic [LEN_W-1:0]      rem,
  output logic [LEN_W-1:0]      size,
  output logic                  roll
);
  localparam logic [LEN_W-1:0] EBUF = LEN_W'(1) << EBUF_LOG2;

  logic [LEN_W-1:0]      room;
  logic [CHIP_SHIFT:0]   sum;

  generate
    if (EBUF_LOG2 == 0) begin : g_unit
      assign room = EBUF;
    end else begin : g_aligned
      assign room = EBUF - LEN_W'(off[EBUF_LOG2-1:0]);
    end
  endgenerate

  always_comb begin
    size = (rem < room) ? rem : room;
    sum  = {1'b0, off} + (CHIP_SHIFT+1)'(size);
    roll = sum[CHIP_SHIFT];
  end
endmodule

// File: rtl/wcs_pos_tracker.sv
// Position registers: chip, in-chip offset, bytes owed, bytes retired.
module wcs_pos_tracker #(
  parameter int CHIP_W     = 4,
  parameter int CHIP_SHIFT = 12,
  parameter int LEN_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [CHIP_W-1:0]     ld_chip,
  input  logic [CHIP_SHIFT-1:0] ld_off,
  input  logic [LEN_W-1:0]      ld_len,
  input  logic                  advance,
  input  logic [LEN_W-1:0]      size,
  input  logic                  roll,
  output logic [CHIP_W-1:0]     chip_q,
  output logic [CHIP_SHIFT-1:0] off_q,
  output logic [LEN_W-1:0]      rem_q,
  output logic [LEN_W-1:0]      bytes_q
);
  logic [CHIP_W-1:0]     chip_d;
  logic [CHIP_SHIFT-1:0] off_d;
  logic [LEN_W-1:0]      rem_d;
  logic [LEN_W-1:0]      bytes_d;
  logic                  en;

  assign en = load | advance;

  always_comb begin
    chip_d  = chip_q;
    off_d   = off_q;
    rem_d   = rem_q;
    bytes_d = bytes_q;
    if (load) begin
      chip_d  = ld_chip;
      off_d   = ld_off;
      rem_d   = ld_len;
      bytes_d = '0;
    end else if (advance) begin
      rem_d   = rem_q - size;
      bytes_d = bytes_q + size;
      if (roll) begin
        chip_d = chip_q + CHIP_W'(1);
        off_d  = '0;
      end else begin
        off_d  = off_q + CHIP_SHIFT'(size);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_q  <= '0;
      off_q   <= '0;
      rem_q   <= '0;
      bytes_q <= '0;
    end else if (en) begin
      chip_q  <= chip_d;
      off_q   <= off_d;
      rem_q   <= rem_d;
      bytes_q <= bytes_d;
    end
  end
endmodule

// File: rtl/wcs_ctrl.sv
// Request sequencing and error capture.
module wcs_ctrl
  import wcs_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             req_empty,
  input  logic             cmd_done,
  input  logic             cmd_err,
  input  logic [ERR_W-1:0] cmd_err_code,
  input  logic             chunk_last,
  output wcs_state_e       state_q,
  output logic             load,
  output logic             advance,
  output logic             err_q,
  output logic [ERR_W-1:0] code_q
);
  wcs_state_e       state_d;
  logic             err_d;
  logic [ERR_W-1:0] code_d;
  logic             issuing;

  assign issuing = (state_q == ST_ISSUE);
  assign load    = (state_q == ST_IDLE) & req_fire;
  assign advance = issuing & cmd_done & ~cmd_err;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_fire) state_d = req_empty ? ST_FIN : ST_ISSUE;
      ST_ISSUE: if (cmd_err || (cmd_done && chunk_last)) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    err_d  = err_q;
    code_d = code_q;
    if (load) begin
      err_d  = 1'b0;
      code_d = '0;
    end else if (issuing && cmd_err) begin
      err_d  = 1'b1;
      code_d = cmd_err_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      code_q  <= code_d;
    end
  end
endmodule

// File: rtl/wchunk_splitter.sv
module wchunk_splitter
  import wcs_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 16,
  parameter int CHIP_SHIFT = 12,
  parameter int BUF_LOG2   = 4,
  parameter int ILV_LOG2   = 1,
  parameter int NCHIP      = 4,
  parameter int ERR_W      = 4,
  localparam int CHIP_W    = ADDR_W - CHIP_SHIFT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_offset,
  input  logic [LEN_W-1:0]      req_len,
  output logic                  req_ready,
  output logic                  cmd_valid,
  output logic [CHIP_W-1:0]     cmd_chip,
  output logic [CHIP_SHIFT-1:0] cmd_offset,
  output logic [LEN_W-1:0]      cmd_size,
  input  logic                  cmd_done,
  input  logic                  cmd_err,
  input  logic [ERR_W-1:0]      cmd_err_code,
  output logic                  fin_valid,
  output logic                  fin_err,
  output logic [ERR_W-1:0]      fin_code,
  output logic [LEN_W-1:0]      fin_bytes
);
  localparam int              EBUF_LOG2 = BUF_LOG2 + ILV_LOG2;
  localparam logic [CHIP_W-1:0] LAST_CHIP = CHIP_W'(NCHIP - 1);

  wcs_state_e           state_q;
  logic                 load, advance, err_q;
  logic [ERR_W-1:0]     code_q;
  logic [CHIP_W-1:0]    ld_chip, chip_q;
  logic [CHIP_SHIFT-1:0] off_q;
  logic [LEN_W-1:0]     rem_q, bytes_q, size;
  logic                 roll, req_fire, req_empty, chunk_last;

  assign ld_chip    = req_offset[ADDR_W-1:CHIP_SHIFT];
  assign req_ready  = (state_q == ST_IDLE);
  assign req_fire   = req_valid & req_ready;
  assign req_empty  = (req_len == '0) | (ld_chip > LAST_CHIP);
  assign chunk_last = (rem_q == size) | (roll & (chip_q == LAST_CHIP));

  wcs_chunk_calc #(
    .CHIP_SHIFT (CHIP_SHIFT),
    .EBUF_LOG2  (EBUF_LOG2),
    .LEN_W      (LEN_W)
  ) u_calc (
    .off  (off_q),
    .rem  (rem_q),
    .size (size),
    .roll (roll)
  );

  wcs_pos_tracker #(
    .CHIP_W     (CHIP_W),
    .CHIP_SHIFT (CHIP_SHIFT),
    .LEN_W      (LEN_W)
  ) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .ld_chip (ld_chip),
    .ld_off  (req_offset[CHIP_SHIFT-1:0]),
    .ld_len  (req_len),
    .advance (advance),
    .size    (size),
    .roll    (roll),
    .chip_q  (chip_q),
    .off_q   (off_q),
    .rem_q   (rem_q),
    .bytes_q (bytes_q)
  );

  wcs_ctrl #(
    .ERR_W (ERR_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_fire     (req_fire),
    .req_empty    (req_empty),
    .cmd_done     (cmd_done),
    .cmd_err      (cmd_err),
    .cmd_err_code (cmd_err_code),
    .chunk_last   (chunk_last),
    .state_q      (state_q),
    .load         (load),
    .advance      (advance),
    .err_q        (err_q),
    .code_q       (code_q)
  );

  assign cmd_valid  = (state_q == ST_ISSUE);
  assign cmd_chip   = chip_q;
  assign cmd_offset = off_q;
  assign cmd_size   = size;
  assign fin_valid  = (state_q == ST_FIN);
  assign fin_err    = err_q;
  assign fin_code   = code_q;
  assign fin_bytes  = bytes_q;
endmodule

// File: rtl/wcs_checker.sv
module wcs_checker #(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 16,
  parameter int CHIP_SHIFT = 12,
  parameter int BUF_LOG2   = 4,
  parameter int ILV_LOG2   = 1,
  parameter int NCHIP      = 4,
  localparam int CHIP_W    = ADDR_W - CHIP_SHIFT
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [LEN_W-1:0]      req_len,
  input logic                  cmd_valid,
  input logic [CHIP_W-1:0]     cmd_chip,
  input logic [CHIP_SHIFT-1:0] cmd_offset,
  input logic [LEN_W-1:0]      cmd_size,
  input logic                  cmd_done,
  input logic                  cmd_err,
  input logic                  fin_valid,
  input logic                  fin_err,
  input logic [LEN_W-1:0]      fin_bytes
);
  localparam int EB = BUF_LOG2 + ILV_LOG2;
  localparam logic [LEN_W:0] EBUF = (LEN_W+1)'(1) << EB;

  logic [LEN_W:0] in_buf_end;
  assign in_buf_end = ((LEN_W+1)'(cmd_offset) & (EBUF - 1'b1)) + (LEN_W+1)'(cmd_size);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fin_valid |=> req_ready && !cmd_valid);

  p_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> fin_valid && !fin_err && fin_bytes == '0 && !cmd_valid);

  p_no_buf_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_size != '0) && (in_buf_end <= EBUF));

  p_chip_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (int'(cmd_chip) < NCHIP));

  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done && !cmd_err) |=> cmd_valid && $stable(cmd_chip) && $stable(cmd_offset) && $stable(cmd_size));

  p_err_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_err) |=> fin_valid && fin_err && $stable(fin_bytes));

  p_bytes_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done && !cmd_err) |=> fin_bytes == $past(fin_bytes) + $past(cmd_size));

  p_fin_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_valid |=> !fin_valid);
endmodule

bind wchunk_splitter wcs_checker #(
  .ADDR_W     (ADDR_W),
  .LEN_W      (LEN_W),
  .CHIP_SHIFT (CHIP_SHIFT),
  .BUF_LOG2   (BUF_LOG2),
  .ILV_LOG2   (ILV_LOG2),
  .NCHIP      (NCHIP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_len    (req_len),
  .cmd_valid  (cmd_valid),
  .cmd_chip   (cmd_chip),
  .cmd_offset (cmd_offset),
  .cmd_size   (cmd_size),
  .cmd_done   (cmd_done),
  .cmd_err    (cmd_err),
  .fin_valid  (fin_valid),
  .fin_err    (fin_err),
  .fin_bytes  (fin_bytes)
);

// File: tb/wchunk_splitter_tb.sv
module wchunk_splitter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CS   = 12;
  localparam int EBUF = 32;
  localparam int NV   = 6;

  localparam int V_OFF [NV] = '{0, 10, 5, 4090, 16380, 8223};
  localparam int V_LEN [NV] = '{64, 100, 3, 20, 50, 1};
  localparam int V_NCH [NV] = '{2, 4, 1, 2, 1, 1};
  localparam int V_BYT [NV] = '{64, 100, 3, 20, 4, 1};
  localparam int V_HLD [NV] = '{0, 3, 0, 0, 0, 2};

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0;
  logic [15:0] req_offset = 0, req_len = 0;
  logic        req_ready, cmd_valid;
  logic [3:0]  cmd_chip;
  logic [11:0] cmd_offset;
  logic [15:0] cmd_size;
  logic        cmd_done = 0, cmd_err = 0;
  logic [3:0]  cmd_err_code = 0;
  logic        fin_valid, fin_err;
  logic [3:0]  fin_code;
  logic [15:0] fin_bytes;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wchunk_splitter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_len(req_len), .req_ready(req_ready), .cmd_valid(cmd_valid),
    .cmd_chip(cmd_chip), .cmd_offset(cmd_offset), .cmd_size(cmd_size),
    .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_err_code(cmd_err_code),
    .fin_valid(fin_valid), .fin_err(fin_err), .fin_code(fin_code),
    .fin_bytes(fin_bytes)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic start(input int off, input int len);
    @(negedge clk);
    req_valid = 1; req_offset = 16'(off); req_len = 16'(len);
    @(negedge clk);
    req_valid = 0;
  endtask

  // Serve commands with an independent position model; err_at < 0 means no error.
  task automatic serve(input int off, input int len, input int err_at, input int code,
                       input bit both, input int hold, output int nch, output int sum);
    int mc, mo, mr, es, guard;
    mc = off >> CS; mo = off % 4096; mr = len; nch = 0; sum = 0; guard = 0;
    while (!fin_valid && guard < 2000) begin
      guard++;
      if (cmd_valid) begin
        es = EBUF - (mo % EBUF);
        if (es > mr) es = mr;
        chk(cmd_chip == mc, (nch == 0) ? "R3 chip" : "R5 chip", cmd_chip, mc);
        chk(cmd_offset == mo, (nch == 0) ? "R3 offset" : "R5 offset", cmd_offset, mo);
        chk(cmd_size == es, "R4 size", cmd_size, es);
        if (nch == 0) begin
          for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(cmd_valid && cmd_size == es && cmd_offset == mo, "R7 hold", cmd_size, es);
          end
        end
        if (nch == err_at) begin
          cmd_err = 1; cmd_done = both; cmd_err_code = 4'(code);
        end else begin
          cmd_done = 1;
          sum += es;
        end
        @(negedge clk);
        cmd_done = 0; cmd_err = 0;
        mo += es; mr -= es; nch++;
        if (mo == 4096) begin mo = 0; mc++; end
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic finish_check(input string tag, input bit eerr, input int ecode,
                              input int ebytes);
    chk(fin_valid == 1, {tag, " fin_valid"}, fin_valid, 1);
    chk(fin_err == eerr, {tag, " fin_err"}, fin_err, eerr);
    if (eerr) chk(fin_code == ecode, {tag, " fin_code"}, fin_code, ecode);
    chk(fin_bytes == ebytes, {tag, " fin_bytes"}, fin_bytes, ebytes);
    @(negedge clk);
    chk(!fin_valid && req_ready, "R9 pulse then ready", fin_valid, 0);
  endtask

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++; n_chk++;
    $display("FAIL R7 watchdog act=hung exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int nch, sum;
    // R1 reset state
    repeat (2) @(negedge clk);
    chk(req_ready && !cmd_valid && !fin_valid, "R1 in reset", {req_ready, cmd_valid, fin_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !cmd_valid && !fin_valid, "R1 after reset", {req_ready, cmd_valid, fin_valid}, 3'b100);

    // Vector table: R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      start(V_OFF[v], V_LEN[v]);
      serve(V_OFF[v], V_LEN[v], -1, 0, 0, V_HLD[v], nch, sum);
      chk(nch == V_NCH[v], (v == 4) ? "R6 chunk count" : "R5 chunk count", nch, V_NCH[v]);
      finish_check((v == 4) ? "R6" : "R9", 0, 0, V_BYT[v]);
    end

    // R2 zero length
    start(100, 0);
    chk(!cmd_valid, "R2 no command", cmd_valid, 0);
    finish_check("R2", 0, 0, 0);

    // R10 start chip beyond array
    start(16'h5000, 10);
    chk(!cmd_valid, "R10 no command", cmd_valid, 0);
    finish_check("R10", 0, 0, 0);

    // R8 error on second chunk
    start(0, 100);
    serve(0, 100, 1, 5, 0, 0, nch, sum);
    chk(nch == 2, "R8 chunks before abort", nch, 2);
    finish_check("R8", 1, 5, 32);

    // R8 error and done together: error wins
    start(10, 100);
    serve(10, 100, 0, 9, 1, 0, nch, sum);
    chk(nch == 1, "R8 both chunk count", nch, 1);
    finish_check("R8 both", 1, 9, 0);

    // Recovery after error, R4 clip on short tail
    start(40, 30);
    serve(40, 30, -1, 0, 0, 0, nch, sum);
    chk(nch == 2, "R4 chunk count", nch, 2);
    finish_check("R9", 0, 0, 30);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule